// File: doc/BRIEF.md
# Graphics Overlay Color-Key Mixer

This block merges a stream of 4-bit graphics indices with a live video stream of 8-bit luma and 8-bit chroma samples, one pixel per clock. A sixteen-entry palette supplies the overlay color for each index. Every palette entry holds a luma value, a chroma value and a transparency flag. A host port writes the entries one at a time.

A two-bit mode field decides how the overlay is placed over the video. In key mode, an external key input picks, pixel by pixel, either the palette color or the live video. In chroma mode, index zero is the reserved transparent index: the video shows through while palette entry 0 keeps its transparency flag set, and every other index shows its palette color. In the two remaining mode codes the video passes straight through. A suspend input stops the block from taking in pixels and palette writes, and forces the outputs to zero.

All pixel, mode and write inputs are sampled on the rising clock edge. The mixed pixel appears on the registered outputs one cycle later in every mode.

Top module: `ovl_key_mixer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, both outputs are zero. After reset every palette entry holds Y=0 and C=0, entry 0 has its transparency flag set and entries 1 to 15 have it clear.
- R2: With mode 2'b00 or 2'b01 and suspend low, the outputs one cycle later equal the video Y and C sampled at the edge, whatever the index and key are.
- R3: With mode 2'b11 (key mode) and key high, the outputs one cycle later equal the Y and C of the palette entry selected by the sampled index.
- R4: With mode 2'b11 and key low, the outputs one cycle later equal the sampled video Y and C.
- R5: With mode 2'b10 (chroma mode) and a nonzero index, the outputs one cycle later equal the palette Y and C of that index.
- R6: With mode 2'b10, index 0, and entry 0's transparency flag set, the outputs one cycle later equal the sampled video Y and C.
- R7: Once entry 0 has been written with its transparency flag clear, index 0 in mode 2'b10 shows entry 0's stored Y and C. Writing the flag set again restores pass-through.
- R8: A palette write takes effect at the edge where it is sampled. A pixel sampled at that same edge uses the entry's old contents. Pixels sampled at later edges use the new contents.
- R9: When suspend is high at an edge, the outputs one cycle later are zero, and a palette write presented at that edge is discarded.
- R10: In key mode the transparency flags have no effect. Key high with index 0 shows entry 0's Y and C even when its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | Freeze: discard inputs, force outputs to zero |
| mode_sel | input | 2 | 11 key mode, 10 chroma mode, 00/01 pass-through |
| key_in | input | 1 | Per-pixel overlay select in key mode |
| gfx_idx | input | 4 | Graphics palette index for the current pixel |
| vid_y | input | 8 | Incoming video luma |
| vid_c | input | 8 | Incoming video chroma |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 4 | Palette entry to write |
| pal_wy | input | 8 | Luma value to store |
| pal_wc | input | 8 | Chroma value to store |
| pal_wtransp | input | 1 | Transparency flag to store |
| mix_y | output | 8 | Mixed luma output, registered |
| mix_c | output | 8 | Mixed chroma output, registered |

## Verification
Every mixed pixel is due exactly one rising edge after its inputs are sampled. The driver applies inputs on the falling edge and queues the expected pixel. The monitor pops that entry two nanoseconds after the next rising edge and compares it with the outputs, so each result is matched to the edge that produced it. A palette write is due one edge after it is sampled. The bench's own palette model therefore updates only after it has computed the expectation for the pixel sampled at the same edge. This holds the same-edge read-old rule in place and shows the new contents from the following pixel on.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    // Overlay mode field encoding
    typedef enum logic [1:0] {
        MODE_THRU_A = 2'b00,
        MODE_THRU_B = 2'b01,
        MODE_CHROMA = 2'b10,
        MODE_EXTKEY = 2'b11
    } mix_mode_e;

endpackage

// File: rtl/ovl_palette.sv
module ovl_palette #(
    parameter int IDX_W = 4,
    parameter int Y_W   = 8,
    parameter int C_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [Y_W-1:0]   wr_y,
    input  logic [C_W-1:0]   wr_c,
    input  logic             wr_transp,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [Y_W-1:0]   rd_y,
    output logic [C_W-1:0]   rd_c,
    output logic             zero_transp
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic           transp;
        logic [Y_W-1:0] y;
        logic [C_W-1:0] c;
    } entry_t;

    entry_t tab_d [DEPTH];
    entry_t tab_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            tab_d[i] = tab_q[i];
        end
        if (wr_en) begin
            tab_d[wr_addr] = '{transp: wr_transp, y: wr_y, c: wr_c};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= '{transp: (i == 0), y: '0, c: '0};
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    // Read side sees registered contents: same-edge write returns old data
    assign rd_y        = tab_q[rd_addr].y;
    assign rd_c        = tab_q[rd_addr].c;
    assign zero_transp = tab_q[0].transp;

endmodule

// File: rtl/ovl_select.sv
module ovl_select
    import ovl_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int Y_W   = 8,
    parameter int C_W   = 8
) (
    input  mix_mode_e        mode,
    input  logic             key,
    input  logic [IDX_W-1:0] idx,
    input  logic [Y_W-1:0]   vid_y,
    input  logic [C_W-1:0]   vid_c,
    input  logic [Y_W-1:0]   pal_y,
    input  logic [C_W-1:0]   pal_c,
    input  logic             zero_transp,
    output logic [Y_W-1:0]   sel_y,
    output logic [C_W-1:0]   sel_c
);
    logic use_pal;

    always_comb begin
        unique case (mode)
            MODE_EXTKEY: use_pal = key;
            MODE_CHROMA: use_pal = !((idx == '0) && zero_transp);
            default:     use_pal = 1'b0;
        endcase
        sel_y = use_pal ? pal_y : vid_y;
        sel_c = use_pal ? pal_c : vid_c;
    end

endmodule

// File: rtl/ovl_key_mixer.sv
module ovl_key_mixer
    import ovl_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int Y_W   = 8,
    parameter int C_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             suspend,
    input  logic [1:0]       mode_sel,
    input  logic             key_in,
    input  logic [IDX_W-1:0] gfx_idx,
    input  logic [Y_W-1:0]   vid_y,
    input  logic [C_W-1:0]   vid_c,
    input  logic             pal_we,
    input  logic [IDX_W-1:0] pal_addr,
    input  logic [Y_W-1:0]   pal_wy,
    input  logic [C_W-1:0]   pal_wc,
    input  logic             pal_wtransp,
    output logic [Y_W-1:0]   mix_y,
    output logic [C_W-1:0]   mix_c
);
    typedef struct packed {
        logic [Y_W-1:0] y;
        logic [C_W-1:0] c;
    } pix_t;

    logic [Y_W-1:0] pal_y, sel_y;
    logic [C_W-1:0] pal_c, sel_c;
    logic           zero_transp;
    pix_t           pix_d, pix_q;

    ovl_palette #(.IDX_W(IDX_W), .Y_W(Y_W), .C_W(C_W)) u_palette (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (pal_we && !suspend),
        .wr_addr     (pal_addr),
        .wr_y        (pal_wy),
        .wr_c        (pal_wc),
        .wr_transp   (pal_wtransp),
        .rd_addr     (gfx_idx),
        .rd_y        (pal_y),
        .rd_c        (pal_c),
        .zero_transp (zero_transp)
    );

    ovl_select #(.IDX_W(IDX_W), .Y_W(Y_W), .C_W(C_W)) u_select (
        .mode        (mix_mode_e'(mode_sel)),
        .key         (key_in),
        .idx         (gfx_idx),
        .vid_y       (vid_y),
        .vid_c       (vid_c),
        .pal_y       (pal_y),
        .pal_c       (pal_c),
        .zero_transp (zero_transp),
        .sel_y       (sel_y),
        .sel_c       (sel_c)
    );

    always_comb begin
        pix_d = '{y: sel_y, c: sel_c};
        if (suspend) begin
            pix_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign mix_y = pix_q.y;
    assign mix_c = pix_q.c;

endmodule

// File: rtl/ovl_mixer_chk.sv
module ovl_mixer_chk #(
    parameter int IDX_W = 4,
    parameter int Y_W   = 8,
    parameter int C_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             suspend,
    input logic [1:0]       mode_sel,
    input logic             key_in,
    input logic [IDX_W-1:0] gfx_idx,
    input logic [Y_W-1:0]   vid_y,
    input logic [C_W-1:0]   vid_c,
    input logic             pal_we,
    input logic [IDX_W-1:0] pal_addr,
    input logic             pal_wtransp,
    input logic [Y_W-1:0]   mix_y,
    input logic [C_W-1:0]   mix_c
);
    // Tracks whether entry 0 currently has its transparency flag cleared
    logic zero_opaque_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_opaque_q <= 1'b0;
        end else if (pal_we && !suspend && pal_addr == '0) begin
            zero_opaque_q <= !pal_wtransp;
        end
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |-> (mix_y == '0 && mix_c == '0));

    a_r2_thru_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && !mode_sel[1]) |=> (mix_y == $past(vid_y) && mix_c == $past(vid_c)));

    a_r4_key_low_video: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && mode_sel == 2'b11 && !key_in) |=> (mix_y == $past(vid_y) && mix_c == $past(vid_c)));

    a_r6_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend && mode_sel == 2'b10 && gfx_idx == '0 && !zero_opaque_q)
        |=> (mix_y == $past(vid_y) && mix_c == $past(vid_c)));

    a_r9_suspend_zero: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> (mix_y == '0 && mix_c == '0));

endmodule

bind ovl_key_mixer ovl_mixer_chk #(.IDX_W(IDX_W), .Y_W(Y_W), .C_W(C_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .suspend     (suspend),
    .mode_sel    (mode_sel),
    .key_in      (key_in),
    .gfx_idx     (gfx_idx),
    .vid_y       (vid_y),
    .vid_c       (vid_c),
    .pal_we      (pal_we),
    .pal_addr    (pal_addr),
    .pal_wtransp (pal_wtransp),
    .mix_y       (mix_y),
    .mix_c       (mix_c)
);

// File: tb/ovl_key_mixer_tb.sv
module ovl_key_mixer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       suspend = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       key_in = 1'b0;
    logic [3:0] gfx_idx = '0;
    logic [7:0] vid_y = '0, vid_c = '0;
    logic       pal_we = 1'b0;
    logic [3:0] pal_addr = '0;
    logic [7:0] pal_wy = '0, pal_wc = '0;
    logic       pal_wtransp = 1'b0;
    logic [7:0] mix_y, mix_c;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    // Bench palette model
    logic [7:0] m_y [16];
    logic [7:0] m_c [16];
    logic       m_t [16];

    always #10 clk = ~clk;

    ovl_key_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .suspend(suspend), .mode_sel(mode_sel),
        .key_in(key_in), .gfx_idx(gfx_idx), .vid_y(vid_y), .vid_c(vid_c),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wy(pal_wy), .pal_wc(pal_wc),
        .pal_wtransp(pal_wtransp), .mix_y(mix_y), .mix_c(mix_c)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one pixel per call, expectation queued for the next edge
    task automatic step(string tag, logic [1:0] md, logic k, logic [3:0] ix,
                        logic [7:0] vy, logic [7:0] vc, logic we = 1'b0,
                        logic [3:0] wa = '0, logic [7:0] wy = '0,
                        logic [7:0] wc = '0, logic wt = 1'b0, logic sus = 1'b0);
        logic [15:0] e;
        logic        pal;
        @(negedge clk);
        mode_sel = md; key_in = k; gfx_idx = ix; vid_y = vy; vid_c = vc;
        pal_we = we; pal_addr = wa; pal_wy = wy; pal_wc = wc; pal_wtransp = wt;
        suspend = sus;
        if (sus) begin
            e = '0;
        end else begin
            if (md == 2'b11)      pal = k;
            else if (md == 2'b10) pal = !(ix == 0 && m_t[0]);
            else                  pal = 1'b0;
            e = pal ? {m_y[ix], m_c[ix]} : {vy, vc};
            if (we) begin
                m_y[wa] = wy; m_c[wa] = wc; m_t[wa] = wt;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), {mix_y, mix_c}, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_y[i] = '0; m_c[i] = '0; m_t[i] = (i == 0);
        end
        repeat (3) @(posedge clk);
        #5;
        check("R1 during reset", {mix_y, mix_c}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1 after release", {mix_y, mix_c}, 16'h0000);

        // R1: reset palette contents visible in key mode
        step("R1 entry9 reset", 2'b11, 1'b1, 4'd9, 8'h77, 8'h66);

        // R2: pass-through codes
        step("R2 mode00", 2'b00, 1'b1, 4'd4, 8'h12, 8'h34);
        step("R2 mode01", 2'b01, 1'b0, 4'd0, 8'hFE, 8'h01);
        step("R2 mode00b", 2'b00, 1'b1, 4'd15, 8'h80, 8'h7F);

        // Load entries 1..15 while passing video
        for (int i = 1; i < 16; i++) begin
            step("R2 load", 2'b01, 1'b1, 4'(i), 8'(i * 3), 8'(i * 5),
                 1'b1, 4'(i), 8'(i * 17), 8'(255 - i * 13), 1'b0);
        end

        // R3 / R4 / R10: key mode
        step("R3 key high idx3", 2'b11, 1'b1, 4'd3, 8'h10, 8'h20);
        step("R3 key high idx15", 2'b11, 1'b1, 4'd15, 8'h10, 8'h20);
        step("R4 key low", 2'b11, 1'b0, 4'd3, 8'hA1, 8'hB2);
        step("R10 key high idx0", 2'b11, 1'b1, 4'd0, 8'hC3, 8'hD4);

        // R5 / R6: chroma mode
        step("R5 idx5", 2'b10, 1'b0, 4'd5, 8'h44, 8'h55);
        step("R5 idx1 key ignored", 2'b10, 1'b1, 4'd1, 8'h44, 8'h55);
        step("R6 idx0 transparent", 2'b10, 1'b1, 4'd0, 8'h9A, 8'hBC);

        // R8: same-edge write reads old, next pixel sees new
        step("R8 same edge old", 2'b10, 1'b0, 4'd7, 8'h00, 8'h00,
             1'b1, 4'd7, 8'hE1, 8'hE2, 1'b0);
        step("R8 next edge new", 2'b10, 1'b0, 4'd7, 8'h00, 8'h00);

        // R9: suspend zeroes output and drops write
        step("R9 suspend zero", 2'b00, 1'b0, 4'd2, 8'h5A, 8'hA5,
             1'b1, 4'd2, 8'hEE, 8'hDD, 1'b0, 1'b1);
        step("R9 write dropped", 2'b10, 1'b0, 4'd2, 8'h11, 8'h22);

        // R7: opaque entry 0, then transparent again
        step("R7 write entry0", 2'b10, 1'b0, 4'd0, 8'h31, 8'h32,
             1'b1, 4'd0, 8'hAA, 8'h55, 1'b0);
        step("R7 idx0 opaque", 2'b10, 1'b0, 4'd0, 8'h31, 8'h32,
             1'b1, 4'd0, 8'hAA, 8'h55, 1'b1);
        step("R7 idx0 restored", 2'b10, 1'b0, 4'd0, 8'h61, 8'h62);

        step("R2 final", 2'b00, 1'b0, 4'd0, 8'h0F, 8'hF0);
        repeat (3) @(posedge clk);
        #4;
        check("R2 queue drained", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        finish_run();
    end

endmodule